// File: doc/BRIEF.md
# Debug TAP with Scan-Chain Selection

This block is a JTAG test access port for debug. It has a five-bit instruction register and a five-bit chain-number register. The TCK, TMS, TDI and TRST inputs drive the standard sixteen-state controller. The current instruction decides which serial register sits between TDI and TDO: the device identifier, a one-bit bypass stage, the chain-number register itself, or one of several internal debug chains.

To pick a chain, a debugger loads the select instruction and shifts in a chain number. The number takes effect only when the controller passes Update-DR. Under the select instruction, Capture-DR loads a fixed check pattern, so the debugger can confirm that the link works. A second instruction routes data scans straight to the instruction chain and leaves the stored chain number unchanged. This makes switching between the data and instruction chains cheap.

Chain 1 holds a 32-bit debug status/control word: the read-only instruction scans it out, and the write instruction updates it at Update-DR. The other chains are stub shift registers that capture a signature. The block reports the routed chain code, a write-mode flag, and capture, shift and update strobes for each chain. It also raises halt and restart requests while the controller idles with the matching instruction.

Top module: `dbg_tap_chainsel`

## Requirements
- R1: While trst_n is low the controller sits in Test-Logic-Reset, tdo and tdo_en are 0, chain_sel is 0, and halt_req and restart_req are 0.
- R2: The instruction register is 5 bits wide and is shifted least significant bit first. Capture-IR loads 5'b00001, so the first bit out is 1. A new opcode takes effect at Update-IR.
- R3: Test-Logic-Reset loads the identify opcode 5'h01. Under that opcode, a data scan shifts out the 32-bit IDCODE_VAL (default 32'h3C5A0F0B) least significant bit first.
- R4: Opcode 5'h1F, and every opcode without a listed function (5'h08 to 5'h1E, and also 5'h05 and 5'h06 for data scans), selects a 1-bit bypass stage that captures 0. The output therefore repeats TDI one bit late.
- R5: Under the select opcode 5'h02, data scans pass through a 5-bit select register whose Capture-DR value is 5'h10. The first five bits out are therefore 0,0,0,0,1.
- R6: The stored chain number changes only in the Update-DR state under opcode 5'h02, and it takes the shifted value. chain_sel reports it (unless R8 applies) from the cycle after Update-DR.
- R7: Chain 1 is a 32-bit status/control word that resets to 0. Opcode 5'h03 reads it without changing it. Opcode 5'h04 (chain_write high) loads the shifted word at Update-DR.
- R8: Opcode 5'h07 routes data scans to chain 4 and sets chain_sel to 4. The stored chain number stays as it was, so a later 5'h03 or 5'h04 reaches the previously selected chain again.
- R9: TDO and tdo_en change on the falling edge of TCK. tdo_en is high only in Shift-IR and Shift-DR, and tdo is 0 whenever tdo_en is low.
- R10: Five TCK cycles with TMS high reach Test-Logic-Reset from any state. That state restores the identify opcode and clears the stored chain number to 0.
- R11: halt_req is high exactly while the controller is in Run-Test/Idle with opcode 5'h05 loaded. restart_req behaves the same way for opcode 5'h06. The two are never high together.
- R12: Chains other than 1 are STUB_W-bit (default 8) registers that capture 8'hC0 OR their index. A stored chain number of NUM_CHAINS (default 8) or more behaves as bypass. At most one chain's capture or shift strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| chain_sel | output | SEL_W | Chain code that data scans are routed to |
| chain_write | output | 1 | High when the current instruction writes the chain |
| chain_capture | output | NUM_CHAINS | Capture-DR strobe per chain |
| chain_shift | output | NUM_CHAINS | Shift-DR strobe per chain |
| chain_update | output | NUM_CHAINS | Update-DR strobe per chain |
| halt_req | output | 1 | Halt request while idle under the halt opcode |
| restart_req | output | 1 | Restart request while idle under the restart opcode |

## Verification
Each register acts on the rising TCK edge at which the controller is in the named state. A captured value appears on TDO at the next falling edge. A chain number or opcode loaded at Update-DR or Update-IR shows on chain_sel or halt_req one rising edge later, when the controller has moved on to Run-Test/Idle. The bench sets TMS and TDI one nanosecond after each falling edge and takes the TDO bit at that same point, so each sampled bit belongs to the state entered at the previous rising edge. It reads chain_sel and the request outputs two nanoseconds after a rising edge. During the Pause-DR, Exit2-DR and Update-DR steps it checks that chain_sel still shows the old number, and it expects the new one only after the Run-Test/Idle edge.

// File: rtl/dbgtap_pkg.sv
package dbgtap_pkg;

   typedef enum logic [3:0] {
      S_TLR, S_RTI,
      S_SEL_DR, S_CAP_DR, S_SHIFT_DR, S_EX1_DR, S_PAUSE_DR, S_EX2_DR, S_UPD_DR,
      S_SEL_IR, S_CAP_IR, S_SHIFT_IR, S_EX1_IR, S_PAUSE_IR, S_EX2_IR, S_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      DP_BYPASS, DP_IDCODE, DP_SELECT, DP_CHAIN
   } dr_path_e;

   // opcode values; all-ones is always the bypass opcode
   localparam int unsigned OP_IDCODE  = 1;
   localparam int unsigned OP_SCANSEL = 2;
   localparam int unsigned OP_INTEST  = 3;
   localparam int unsigned OP_EXTEST  = 4;
   localparam int unsigned OP_HALT    = 5;
   localparam int unsigned OP_RESTART = 6;
   localparam int unsigned OP_ICHAIN  = 7;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
      tap_state_e n;
      case (s)
         S_TLR:      n = tms ? S_TLR      : S_RTI;
         S_RTI:      n = tms ? S_SEL_DR   : S_RTI;
         S_SEL_DR:   n = tms ? S_SEL_IR   : S_CAP_DR;
         S_CAP_DR:   n = tms ? S_EX1_DR   : S_SHIFT_DR;
         S_SHIFT_DR: n = tms ? S_EX1_DR   : S_SHIFT_DR;
         S_EX1_DR:   n = tms ? S_UPD_DR   : S_PAUSE_DR;
         S_PAUSE_DR: n = tms ? S_EX2_DR   : S_PAUSE_DR;
         S_EX2_DR:   n = tms ? S_UPD_DR   : S_SHIFT_DR;
         S_UPD_DR:   n = tms ? S_SEL_DR   : S_RTI;
         S_SEL_IR:   n = tms ? S_TLR      : S_CAP_IR;
         S_CAP_IR:   n = tms ? S_EX1_IR   : S_SHIFT_IR;
         S_SHIFT_IR: n = tms ? S_EX1_IR   : S_SHIFT_IR;
         S_EX1_IR:   n = tms ? S_UPD_IR   : S_PAUSE_IR;
         S_PAUSE_IR: n = tms ? S_EX2_IR   : S_PAUSE_IR;
         S_EX2_IR:   n = tms ? S_UPD_IR   : S_SHIFT_IR;
         S_UPD_IR:   n = tms ? S_SEL_DR   : S_RTI;
         default:    n = S_TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dbgtap_fsm.sv
module dbgtap_fsm
   import dbgtap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= S_TLR;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/dbgtap_ir.sv
module dbgtap_ir
   import dbgtap_pkg::*;
#(
   parameter int unsigned IR_W = 5
)(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so
);

   localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
   localparam logic [IR_W-1:0] IR_RESET   = IR_W'(OP_IDCODE);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= IR_CAPTURE;
         ir_q  <= IR_RESET;
      end else begin
         case (state)
            S_TLR:      ir_q  <= IR_RESET;
            S_CAP_IR:   ir_sr <= IR_CAPTURE;
            S_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            S_UPD_IR:   ir_q  <= ir_sr;
            default: ;
         endcase
      end
   end

   assign ir_so = ir_sr[0];

endmodule

// File: rtl/dbgtap_chain.sv
module dbgtap_chain #(
   parameter int unsigned  W        = 8,
   parameter bit           HOLD     = 1'b0,
   parameter logic [W-1:0] INIT_VAL = '0
)(
   input  logic tck,
   input  logic trst_n,
   input  logic cap,
   input  logic shift,
   input  logic upd,
   input  logic wr,
   input  logic tdi,
   output logic so
);

   logic [W-1:0] sr;
   logic [W-1:0] cap_val;

   generate
      if (HOLD) begin : g_hold
         logic [W-1:0] hold;
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)        hold <= INIT_VAL;
            else if (upd && wr) hold <= sr;
         end
         assign cap_val = hold;
      end else begin : g_const
         logic unused_ctl;
         assign unused_ctl = upd ^ wr;
         assign cap_val    = INIT_VAL;
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)    sr <= '0;
      else if (cap)   sr <= cap_val;
      else if (shift) sr <= {tdi, sr[W-1:1]};
   end

   assign so = sr[0];

endmodule

// File: rtl/dbg_tap_chainsel.sv
module dbg_tap_chainsel
   import dbgtap_pkg::*;
#(
   parameter int unsigned      IR_W        = 5,
   parameter int unsigned      SEL_W       = 5,
   parameter int unsigned      NUM_CHAINS  = 8,
   parameter int unsigned      STAT_CHAIN  = 1,
   parameter int unsigned      INSTR_CHAIN = 4,
   parameter int unsigned      STAT_W      = 32,
   parameter int unsigned      STUB_W      = 8,
   parameter logic [31:0]      IDCODE_VAL  = 32'h3C5A_0F0B,
   parameter logic [STUB_W-1:0] STUB_SIG   = STUB_W'(8'hC0),
   parameter logic [STAT_W-1:0] STAT_RST   = '0
)(
   input  logic                  tck,
   input  logic                  trst_n,
   input  logic                  tms,
   input  logic                  tdi,
   output logic                  tdo,
   output logic                  tdo_en,
   output logic [SEL_W-1:0]      chain_sel,
   output logic                  chain_write,
   output logic [NUM_CHAINS-1:0] chain_capture,
   output logic [NUM_CHAINS-1:0] chain_shift,
   output logic [NUM_CHAINS-1:0] chain_update,
   output logic                  halt_req,
   output logic                  restart_req
);

   localparam int unsigned        CH_IW    = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;
   localparam logic [SEL_W:0]     NUM_CH_L = (SEL_W+1)'(NUM_CHAINS);
   localparam logic [SEL_W-1:0]   SEL_CAP  = {1'b1, {(SEL_W-1){1'b0}}};
   localparam logic [SEL_W-1:0]   ICH_ID   = SEL_W'(INSTR_CHAIN);
   localparam logic [IR_W-1:0]    OPC_ID   = IR_W'(OP_IDCODE);
   localparam logic [IR_W-1:0]    OPC_SEL  = IR_W'(OP_SCANSEL);
   localparam logic [IR_W-1:0]    OPC_INT  = IR_W'(OP_INTEST);
   localparam logic [IR_W-1:0]    OPC_EXT  = IR_W'(OP_EXTEST);
   localparam logic [IR_W-1:0]    OPC_HALT = IR_W'(OP_HALT);
   localparam logic [IR_W-1:0]    OPC_RST  = IR_W'(OP_RESTART);
   localparam logic [IR_W-1:0]    OPC_ICH  = IR_W'(OP_ICHAIN);

   // elaboration-time parameter checks
   generate
      if (IR_W < 3)                      begin : g_bad_ir    $error("IR_W must be at least 3");            end
      if (SEL_W < 2)                     begin : g_bad_sel   $error("SEL_W must be at least 2");           end
      if (NUM_CHAINS < 2)                begin : g_bad_nch   $error("NUM_CHAINS must be at least 2");      end
      if (NUM_CHAINS > (1 << SEL_W))     begin : g_bad_span  $error("NUM_CHAINS exceeds SEL_W range");     end
      if (STAT_CHAIN >= NUM_CHAINS)      begin : g_bad_stat  $error("STAT_CHAIN out of range");            end
      if (INSTR_CHAIN >= NUM_CHAINS)     begin : g_bad_ich   $error("INSTR_CHAIN out of range");           end
      if (STAT_CHAIN == INSTR_CHAIN)     begin : g_bad_same  $error("status and instruction chains clash"); end
      if (STAT_W < 2 || STUB_W < 2)      begin : g_bad_w     $error("chain widths must be at least 2");    end
   endgenerate

   tap_state_e      state;
   logic [IR_W-1:0] ir_q;
   logic            ir_so;

   dbgtap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   dbgtap_ir #(.IR_W(IR_W)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (state),
      .tdi    (tdi),
      .ir_q   (ir_q),
      .ir_so  (ir_so)
   );

   // instruction decode
   logic op_id, op_sel, op_int, op_ext, op_ich;
   assign op_id  = (ir_q == OPC_ID);
   assign op_sel = (ir_q == OPC_SEL);
   assign op_int = (ir_q == OPC_INT);
   assign op_ext = (ir_q == OPC_EXT);
   assign op_ich = (ir_q == OPC_ICH);

   // chain-number register and its check-pattern shifter
   logic [SEL_W-1:0] sel_sr;
   logic [SEL_W-1:0] chain_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sel_sr  <= SEL_CAP;
         chain_q <= '0;
      end else if (state == S_TLR) begin
         chain_q <= '0;
      end else if (op_sel) begin
         case (state)
            S_CAP_DR:   sel_sr  <= SEL_CAP;
            S_SHIFT_DR: sel_sr  <= {tdi, sel_sr[SEL_W-1:1]};
            S_UPD_DR:   chain_q <= sel_sr;
            default: ;
         endcase
      end
   end

   logic [SEL_W-1:0] act_chain;
   logic             chain_ok;
   dr_path_e         path;

   assign act_chain = op_ich ? ICH_ID : chain_q;
   assign chain_ok  = (op_int || op_ext || op_ich) && ({1'b0, act_chain} < NUM_CH_L);

   always_comb begin
      if (op_id)         path = DP_IDCODE;
      else if (op_sel)   path = DP_SELECT;
      else if (chain_ok) path = DP_CHAIN;
      else               path = DP_BYPASS;
   end

   assign chain_sel   = act_chain;
   assign chain_write = op_ext || op_ich;
   assign halt_req    = (state == S_RTI) && (ir_q == OPC_HALT);
   assign restart_req = (state == S_RTI) && (ir_q == OPC_RST);

   // identifier and bypass registers
   logic [31:0] id_sr;
   logic        byp_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_sr <= IDCODE_VAL;
         byp_q <= 1'b0;
      end else begin
         if (path == DP_IDCODE) begin
            if (state == S_CAP_DR)        id_sr <= IDCODE_VAL;
            else if (state == S_SHIFT_DR) id_sr <= {tdi, id_sr[31:1]};
         end
         if (path == DP_BYPASS) begin
            if (state == S_CAP_DR)        byp_q <= 1'b0;
            else if (state == S_SHIFT_DR) byp_q <= tdi;
         end
      end
   end

   // per-chain strobes and chain registers
   logic [NUM_CHAINS-1:0] chain_so;

   generate
      for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_ch
         localparam logic [SEL_W-1:0] K_ID = SEL_W'(k);
         logic hit;
         assign hit              = (path == DP_CHAIN) && (act_chain == K_ID);
         assign chain_capture[k] = hit && (state == S_CAP_DR);
         assign chain_shift[k]   = hit && (state == S_SHIFT_DR);
         assign chain_update[k]  = hit && (state == S_UPD_DR);

         if (k == STAT_CHAIN) begin : g_stat
            dbgtap_chain #(.W(STAT_W), .HOLD(1'b1), .INIT_VAL(STAT_RST)) u_chain (
               .tck    (tck),
               .trst_n (trst_n),
               .cap    (chain_capture[k]),
               .shift  (chain_shift[k]),
               .upd    (chain_update[k]),
               .wr     (chain_write),
               .tdi    (tdi),
               .so     (chain_so[k])
            );
         end else begin : g_stub
            dbgtap_chain #(.W(STUB_W), .HOLD(1'b0), .INIT_VAL(STUB_SIG | STUB_W'(k))) u_chain (
               .tck    (tck),
               .trst_n (trst_n),
               .cap    (chain_capture[k]),
               .shift  (chain_shift[k]),
               .upd    (chain_update[k]),
               .wr     (chain_write),
               .tdi    (tdi),
               .so     (chain_so[k])
            );
         end
      end
   endgenerate

   logic dr_so;
   always_comb begin
      case (path)
         DP_IDCODE: dr_so = id_sr[0];
         DP_SELECT: dr_so = sel_sr[0];
         DP_CHAIN:  dr_so = chain_so[act_chain[CH_IW-1:0]];
         default:   dr_so = byp_q;
      endcase
   end

   // serial output, launched on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == S_SHIFT_IR) || (state == S_SHIFT_DR);
         if (state == S_SHIFT_IR)      tdo <= ir_so;
         else if (state == S_SHIFT_DR) tdo <= dr_so;
         else                          tdo <= 1'b0;
      end
   end

endmodule

// File: rtl/dbgtap_chk.sv
module dbgtap_chk
   import dbgtap_pkg::*;
#(
   parameter int unsigned IR_W        = 5,
   parameter int unsigned SEL_W       = 5,
   parameter int unsigned NUM_CHAINS  = 8,
   parameter int unsigned INSTR_CHAIN = 4
)(
   input logic                  tck,
   input logic                  trst_n,
   input tap_state_e            state,
   input logic [IR_W-1:0]       ir_q,
   input logic [SEL_W-1:0]      sel_sr,
   input logic [SEL_W-1:0]      chain_q,
   input logic [NUM_CHAINS-1:0] chain_capture,
   input logic [NUM_CHAINS-1:0] chain_shift,
   input logic                  tdo,
   input logic                  tdo_en,
   input logic                  halt_req,
   input logic                  restart_req
);

   localparam logic [SEL_W-1:0] SEL_CAP = {1'b1, {(SEL_W-1){1'b0}}};

   // R5
   sel_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_CAP_DR && ir_q == IR_W'(OP_SCANSEL)) |=> (sel_sr == SEL_CAP));

   // R6
   chain_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state != S_UPD_DR && state != S_TLR) |=> $stable(chain_q));

   // R8
   ichain_route_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_CAP_DR && ir_q == IR_W'(OP_ICHAIN)) |-> chain_capture[INSTR_CHAIN]);

   // R9
   tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_en |-> !tdo);

   // R9
   tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == (state == S_SHIFT_DR || state == S_SHIFT_IR));

   // R10
   tlr_restore_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_TLR) |=> (ir_q == IR_W'(OP_IDCODE) && chain_q == '0));

   // R11
   req_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({halt_req, restart_req}));

   // R11
   req_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (halt_req || restart_req) |-> state == S_RTI);

   // R12
   cap_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(chain_capture));

   // R12
   shift_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(chain_shift));

endmodule

bind dbg_tap_chainsel dbgtap_chk #(
   .IR_W        (IR_W),
   .SEL_W       (SEL_W),
   .NUM_CHAINS  (NUM_CHAINS),
   .INSTR_CHAIN (INSTR_CHAIN)
) u_chk (
   .tck           (tck),
   .trst_n        (trst_n),
   .state         (state),
   .ir_q          (ir_q),
   .sel_sr        (sel_sr),
   .chain_q       (chain_q),
   .chain_capture (chain_capture),
   .chain_shift   (chain_shift),
   .tdo           (tdo),
   .tdo_en        (tdo_en),
   .halt_req      (halt_req),
   .restart_req   (restart_req)
);

// File: tb/sim_dbg_tap_chainsel.sv
`timescale 1ns/1ps
module sim_dbg_tap_chainsel;

   localparam logic [31:0] IDV      = 32'h3C5A_0F0B;
   localparam int          NCH      = 8;
   localparam logic [31:0] WR_WORD  = 32'h5A3C_96E1;
   localparam logic [31:0] ALT_WORD = 32'h0F0F_1234;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       tdo, tdo_en, chain_write, halt_req, restart_req;
   logic [4:0] chain_sel;
   logic [7:0] chain_capture, chain_shift, chain_update;

   int checks = 0;
   int fails  = 0;
   int en_miss = 0;
   logic last_tdo, last_en;
   logic [31:0] stat_model = '0;

   always #5 tck = ~tck;

   dbg_tap_chainsel u0 (
      .tck           (tck),
      .trst_n        (trst_n),
      .tms           (tms),
      .tdi           (tdi),
      .tdo           (tdo),
      .tdo_en        (tdo_en),
      .chain_sel     (chain_sel),
      .chain_write   (chain_write),
      .chain_capture (chain_capture),
      .chain_shift   (chain_shift),
      .chain_update  (chain_update),
      .halt_req      (halt_req),
      .restart_req   (restart_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one TCK cycle: sample TDO after the falling edge, drive TMS/TDI, pass the rising edge
   task automatic tick(input logic m, input logic d);
      @(negedge tck);
      #1;
      last_tdo = tdo;
      last_en  = tdo_en;
      tms = m;
      tdi = d;
      @(posedge tck);
      #2;
   endtask

   task automatic scan_ir(input logic [4:0] v, output logic [4:0] cap);
      cap = '0;
      tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) begin
         tick(i == 4, v[i]);
         cap[i] = last_tdo;
         if (!last_en) en_miss++;
      end
      tick(1'b1, 1'b0); tick(1'b0, 1'b0);
   endtask

   task automatic dr_enter;
      tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
   endtask

   task automatic dr_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i]);
         dout[i] = last_tdo;
         if (!last_en) en_miss++;
      end
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      dr_enter();
      dr_bits(n, din, dout);
      tick(1'b1, 1'b0); tick(1'b0, 1'b0);
   endtask

   initial begin
      logic [4:0]  cap;
      logic [31:0] dout;
      logic [7:0]  exp8;

      repeat (3) @(posedge tck);
      #2;
      // R1: reset state
      chk("R1 chain_sel", {27'b0, chain_sel}, 0);
      chk("R1 tdo_en", {31'b0, tdo_en}, 0);
      chk("R1 tdo", {31'b0, tdo}, 0);
      chk("R1 requests", {30'b0, halt_req, restart_req}, 0);
      trst_n = 1'b1;
      tick(1'b0, 1'b0);
      chk("R9 idle tdo_en", {31'b0, last_en}, 0);

      // R3: identifier after reset
      scan_dr(32, 32'h0, dout);
      chk("R3 idcode", dout, IDV);

      // sweep every chain number (R5, R6, R12, R7 reset value)
      for (int c = 0; c < 32; c++) begin
         scan_ir(5'h02, cap);
         chk("R2 ir capture", {27'b0, cap}, 32'h1);
         scan_dr(5, c, dout);
         chk("R5 select pattern", dout, 32'h10);
         scan_ir(5'h03, cap);
         chk("R6 chain_sel", {27'b0, chain_sel}, c);
         scan_dr(8, 32'h3C, dout);
         if (c == 1)        exp8 = stat_model[7:0];
         else if (c < NCH)  exp8 = 8'hC0 | 8'(c);
         else               exp8 = 8'h78;
         chk("R12 chain data", dout, {24'b0, exp8});
      end

      // R7: write and read the status word on chain 1
      scan_ir(5'h02, cap);
      scan_dr(5, 1, dout);
      scan_ir(5'h04, cap);
      chk("R7 write flag", {31'b0, chain_write}, 1);
      scan_dr(32, WR_WORD, dout);
      stat_model = WR_WORD;
      scan_ir(5'h03, cap);
      chk("R7 read flag", {31'b0, chain_write}, 0);
      scan_dr(32, ALT_WORD, dout);
      chk("R7 read after write", dout, WR_WORD);
      scan_dr(32, 32'h0, dout);
      chk("R7 read leaves word", dout, WR_WORD);

      // R8: instruction-chain shortcut
      scan_ir(5'h07, cap);
      chk("R8 chain_sel", {27'b0, chain_sel}, 4);
      scan_dr(8, 32'h0, dout);
      chk("R8 chain 4 data", dout, 32'hC4);
      scan_ir(5'h03, cap);
      chk("R8 stored chain kept", {27'b0, chain_sel}, 1);
      scan_dr(32, 32'h0, dout);
      chk("R8 status reachable", dout, WR_WORD);

      // R6: new chain only after Update-DR
      scan_ir(5'h02, cap);
      dr_enter();
      dr_bits(5, 32'd3, dout);
      tick(1'b0, 1'b0);
      chk("R6 pause keeps chain", {27'b0, chain_sel}, 1);
      tick(1'b1, 1'b0);
      tick(1'b1, 1'b0);
      chk("R6 update state keeps chain", {27'b0, chain_sel}, 1);
      tick(1'b0, 1'b0);
      chk("R6 chain after update", {27'b0, chain_sel}, 3);

      // R10: five TMS-high cycles
      scan_ir(5'h03, cap);
      chk("R10 before reset", {27'b0, chain_sel}, 3);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      chk("R10 chain cleared", {27'b0, chain_sel}, 0);
      scan_dr(32, 32'h0, dout);
      chk("R10 idcode restored", dout, IDV);

      // R11: halt and restart requests
      scan_ir(5'h05, cap);
      chk("R11 halt idle", {30'b0, halt_req, restart_req}, 32'h2);
      scan_ir(5'h06, cap);
      chk("R11 restart idle", {30'b0, halt_req, restart_req}, 32'h1);
      tick(1'b1, 1'b0);
      chk("R11 restart leaves idle", {30'b0, halt_req, restart_req}, 0);
      tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);

      // R4: bypass for the bypass opcode and all unlisted ones
      for (int op = 5; op < 32; op++) begin
         if (op == 7) continue;
         scan_ir(5'(op), cap);
         chk("R2 ir capture", {27'b0, cap}, 32'h1);
         scan_dr(8, 32'hA5, dout);
         chk("R4 bypass", dout, 32'h4A);
      end

      // R9: output enable during every shift bit
      chk("R9 shift enable", en_miss, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge tck);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule